// File: doc/BRIEF.md
# UART Receive Character Queue with Trigger-Level Interrupt

This block sits between the serial receiver of a UART and the host. Each completed character from the receive shift register arrives as a one-cycle push and is stored in a 16-deep, 8-bit first-in first-out queue. The host sees the oldest stored character on its read port and removes it by pulsing a pop, which is the effect of reading the receive holding register.

The block derives two status indications from the queue occupancy. The data-ready flag is high whenever at least one character is waiting. The receive-data-available interrupt is level-based: it is high while the occupancy is at or above a trigger level chosen by a 2-bit select, and it drops without host action as soon as the occupancy falls below that level. An interrupt identification code reports the same condition. The queue-enable and receive-interrupt-enable inputs set how the interrupt is gated. A push that finds the queue full is discarded and raises a one-cycle overrun pulse.

Top module: `uart_rx_fifo_trig`

## Requirements
- R1: The queue holds up to 16 characters in arrival order; `host_char` shows the oldest stored character whenever `rx_level` is nonzero, and a pop removes that character.
- R2: `rx_level` gives the number of stored characters (0 to 16) and changes at the clock edge that accepts a push or a pop.
- R3: A push while the queue holds 16 characters and no pop is requested is discarded, the stored contents stay unchanged, and `overrun` is high for exactly the one cycle after that edge.
- R4: A push and a pop in the same cycle on a non-empty queue leave `rx_level` unchanged and keep character order; a pop on an empty queue has no effect.
- R5: `data_ready` goes high at the edge that stores a character into an empty queue and stays high until the queue is empty again, whatever pops come before that.
- R6: `trig_sel` selects the trigger level: 2'b00 = 1, 2'b01 = 4, 2'b10 = 8, 2'b11 = 14 characters.
- R7: With `fifo_en` = 1 and `rx_irq_en` = 1, `rx_irq` is high exactly while `rx_level` is at or above the selected trigger level, and it falls when the level drops below it.
- R8: `isr_code` is 4'b0100 (bit 2 set, receive data available) while `rx_irq` is high and 4'b0001 (bit 0 set, nothing pending) otherwise.
- R9: With `rx_irq_en` = 0, `rx_irq` stays low and `isr_code` stays 4'b0001, while `data_ready` still follows queue emptiness.
- R10: With `fifo_en` = 0 the trigger level is one character whatever `trig_sel` holds.
- R11: After reset the queue is empty: `rx_level` = 0, `data_ready` = 0, `rx_irq` = 0, `overrun` = 0, `isr_code` = 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_push | input | 1 | A completed character is offered from the shift register |
| rx_char | input | 8 | Character offered with `rx_push` |
| host_pop | input | 1 | Host reads the holding register and removes the oldest character |
| fifo_en | input | 1 | Queue mode enable; when low the trigger level is one character |
| rx_irq_en | input | 1 | Receive-data interrupt enable |
| trig_sel | input | 2 | Trigger level select |
| host_char | output | 8 | Oldest stored character |
| rx_level | output | 5 | Number of stored characters |
| data_ready | output | 1 | At least one character is stored |
| rx_irq | output | 1 | Receive-data-available interrupt |
| isr_code | output | 4 | Interrupt identification code |
| overrun | output | 1 | One-cycle pulse after a push was dropped on a full queue |

## Verification
Every push or pop takes effect at one clock edge, so `rx_level`, `host_char` and `data_ready` are due right after that edge, and `overrun` is registered and therefore also shows up in the cycle just after the dropping edge. `rx_irq` and `isr_code` are combinational from the stored level and the configuration inputs, so a change of `trig_sel`, `fifo_en` or `rx_irq_en` shows in the same cycle, while a level change shows after the edge. The bench keeps a behavioural queue that it advances at each rising edge. At each falling edge it compares every output with that queue, evaluated against the configuration inputs applied at that time. New stimulus is driven only after that comparison.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   typedef enum logic [1:0] {
      TRIG_ONE      = 2'b00,
      TRIG_FOUR     = 2'b01,
      TRIG_EIGHT    = 2'b10,
      TRIG_FOURTEEN = 2'b11
   } trig_sel_e;

   localparam int unsigned ISR_W = 4;
   localparam logic [ISR_W-1:0] ISR_RX_AVAIL = 4'b0100;
   localparam logic [ISR_W-1:0] ISR_NONE     = 4'b0001;

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              pop_i,
   output logic [DATA_W-1:0] head_o,
   output logic [CW-1:0]     count_o,
   output logic              overrun_o
);

   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]     count_q;
   logic              full, empty, push_ok, pop_ok, ovr_q;

   assign full    = (count_q == FULL_CNT);
   assign empty   = (count_q == '0);
   assign push_ok = push_i && (!full || pop_i);
   assign pop_ok  = pop_i && !empty;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_cmp_wrap
         assign wr_nxt = (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) begin
         mem[wr_ptr] <= data_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count_q <= '0;
         ovr_q   <= 1'b0;
      end else begin
         ovr_q <= push_i && full && !pop_i;
         if (push_ok) begin
            wr_ptr <= wr_nxt;
         end
         if (pop_ok) begin
            rd_ptr <= rd_nxt;
         end
         case ({push_ok, pop_ok})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   assign head_o    = mem[rd_ptr];
   assign count_o   = count_q;
   assign overrun_o = ovr_q;

   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= FULL_CNT);

   assert_overrun_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_o |-> (count_q == FULL_CNT));

   assert_pushpop_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && pop_i && !empty) |=> $stable(count_q));

   assert_pop_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && empty) |=> (count_q == '0));

endmodule

// File: rtl/rxq_trigger.sv
module rxq_trigger
   import rxq_pkg::*;
#(
   parameter int unsigned CW      = 5,
   parameter int unsigned TRIG_L0 = 1,
   parameter int unsigned TRIG_L1 = 4,
   parameter int unsigned TRIG_L2 = 8,
   parameter int unsigned TRIG_L3 = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CW-1:0]    count_i,
   input  logic             fifo_en_i,
   input  logic             irq_en_i,
   input  logic [1:0]       sel_i,
   output logic             irq_o,
   output logic [ISR_W-1:0] status_o
);

   localparam logic [CW-1:0] LVL0 = CW'(TRIG_L0);
   localparam logic [CW-1:0] LVL1 = CW'(TRIG_L1);
   localparam logic [CW-1:0] LVL2 = CW'(TRIG_L2);
   localparam logic [CW-1:0] LVL3 = CW'(TRIG_L3);
   localparam logic [CW-1:0] LVL_SINGLE = CW'(1);

   logic [CW-1:0] thr;
   logic          reached;

   always_comb begin
      if (!fifo_en_i) begin
         thr = LVL_SINGLE;
      end else begin
         unique case (trig_sel_e'(sel_i))
            TRIG_ONE:      thr = LVL0;
            TRIG_FOUR:     thr = LVL1;
            TRIG_EIGHT:    thr = LVL2;
            TRIG_FOURTEEN: thr = LVL3;
            default:       thr = LVL3;
         endcase
      end
   end

   assign reached  = (count_i >= thr);
   assign irq_o    = irq_en_i && reached;
   assign status_o = irq_o ? ISR_RX_AVAIL : ISR_NONE;

   assert_irq_has_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (count_i != '0));

   assert_status_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (status_o == ISR_RX_AVAIL));

   assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en_i |-> (!irq_o && status_o == ISR_NONE));

endmodule

// File: rtl/uart_rx_fifo_trig.sv
module uart_rx_fifo_trig
   import rxq_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned TRIG_L0 = 1,
   parameter int unsigned TRIG_L1 = 4,
   parameter int unsigned TRIG_L2 = 8,
   parameter int unsigned TRIG_L3 = 14,
   localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_push,
   input  logic [DATA_W-1:0] rx_char,
   input  logic              host_pop,
   input  logic              fifo_en,
   input  logic              rx_irq_en,
   input  logic [1:0]        trig_sel,
   output logic [DATA_W-1:0] host_char,
   output logic [CW-1:0]     rx_level,
   output logic              data_ready,
   output logic              rx_irq,
   output logic [ISR_W-1:0]  isr_code,
   output logic              overrun
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (TRIG_L0 < 1 || TRIG_L0 > DEPTH || TRIG_L1 < 1 || TRIG_L1 > DEPTH ||
          TRIG_L2 < 1 || TRIG_L2 > DEPTH || TRIG_L3 < 1 || TRIG_L3 > DEPTH) begin : g_bad_trig
         $error("every trigger level must lie in 1..DEPTH");
      end
   endgenerate

   logic [CW-1:0] level;

   rxq_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_i    (rx_push),
      .data_i    (rx_char),
      .pop_i     (host_pop),
      .head_o    (host_char),
      .count_o   (level),
      .overrun_o (overrun)
   );

   rxq_trigger #(
      .CW      (CW),
      .TRIG_L0 (TRIG_L0),
      .TRIG_L1 (TRIG_L1),
      .TRIG_L2 (TRIG_L2),
      .TRIG_L3 (TRIG_L3)
   ) u_trig (
      .clk       (clk),
      .rst_n     (rst_n),
      .count_i   (level),
      .fifo_en_i (fifo_en),
      .irq_en_i  (rx_irq_en),
      .sel_i     (trig_sel),
      .irq_o     (rx_irq),
      .status_o  (isr_code)
   );

   assign rx_level   = level;
   assign data_ready = (level != '0);

   assert_ready_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && level == '0) |=> data_ready);

   assert_ready_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (data_ready && !host_pop) |=> data_ready);

   assert_ready_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_pop && !rx_push && level == CW'(1)) |=> !data_ready);

   assert_irq_implies_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> data_ready);

endmodule

// File: tb/uart_rx_fifo_trig_bench.sv
`timescale 1ns/1ps
module uart_rx_fifo_trig_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_push = 1'b0;
   logic [7:0] rx_char = '0;
   logic       host_pop = 1'b0;
   logic       fifo_en = 1'b1;
   logic       rx_irq_en = 1'b1;
   logic [1:0] trig_sel = 2'b00;
   logic [7:0] host_char;
   logic [4:0] rx_level;
   logic       data_ready;
   logic       rx_irq;
   logic [3:0] isr_code;
   logic       overrun;

   int nchk = 0;
   int nfail = 0;
   int q[$];
   bit m_ovr = 1'b0;
   bit last_both = 1'b0;
   int unsigned lfsr = 32'h1ACE_B00C;
   logic [7:0] seq = 8'h10;

   always #10 clk = ~clk;

   uart_rx_fifo_trig u_uart_rx_fifo_trig (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_push    (rx_push),
      .rx_char    (rx_char),
      .host_pop   (host_pop),
      .fifo_en    (fifo_en),
      .rx_irq_en  (rx_irq_en),
      .trig_sel   (trig_sel),
      .host_char  (host_char),
      .rx_level   (rx_level),
      .data_ready (data_ready),
      .rx_irq     (rx_irq),
      .isr_code   (isr_code),
      .overrun    (overrun)
   );

   // behavioural reference queue, advanced at each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         m_ovr = 1'b0;
         last_both = 1'b0;
      end else begin
         bit do_pop, do_push;
         m_ovr = rx_push && (q.size() == 16) && !host_pop;
         do_pop = host_pop && (q.size() > 0);
         do_push = rx_push && ((q.size() < 16) || host_pop);
         last_both = rx_push && host_pop && (q.size() > 0);
         if (do_pop) void'(q.pop_front());
         if (do_push) q.push_back(int'(rx_char));
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int exp_thr();
      if (!fifo_en) return 1;
      case (trig_sel)
         2'b00: return 1;
         2'b01: return 4;
         2'b10: return 8;
         default: return 14;
      endcase
   endfunction

   task automatic check_all();
      int lvl;
      bit e_irq;
      string itag;
      lvl = q.size();
      e_irq = rx_irq_en && (lvl >= exp_thr());
      if (!rx_irq_en) itag = "R9 irq masked";
      else if (!fifo_en) itag = "R10 single-char trigger";
      else itag = "R7/R6 trigger irq";
      chk(int'(rx_level) == lvl, last_both ? "R4 level on push+pop" : "R2 level",
          int'(rx_level), lvl);
      if (lvl > 0)
         chk(int'(host_char) == q[0], last_both ? "R4 order on push+pop" : "R1 head char",
             int'(host_char), q[0]);
      chk(data_ready == (lvl > 0), "R5 data_ready", int'(data_ready), int'(lvl > 0));
      chk(rx_irq == e_irq, itag, int'(rx_irq), int'(e_irq));
      chk(isr_code == (e_irq ? 4'b0100 : 4'b0001), "R8 isr_code", int'(isr_code),
          e_irq ? 4 : 1);
      chk(overrun == m_ovr, "R3 overrun", int'(overrun), int'(m_ovr));
   endtask

   task automatic cyc(input bit p, input bit r);
      @(negedge clk);
      check_all();
      rx_push = p;
      host_pop = r;
      if (p) begin
         rx_char = seq;
         seq = seq + 8'd7;
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(rx_level == 5'd0, "R11 reset level", int'(rx_level), 0);
      chk(data_ready == 1'b0, "R11 reset data_ready", int'(data_ready), 0);
      chk(rx_irq == 1'b0, "R11 reset irq", int'(rx_irq), 0);
      chk(overrun == 1'b0, "R11 reset overrun", int'(overrun), 0);
      chk(isr_code == 4'b0001, "R11 reset isr_code", int'(isr_code), 1);
      rst_n = 1'b1;

      // trigger at 4: fill past it, then drain, then pop on empty
      fifo_en = 1'b1; rx_irq_en = 1'b1; trig_sel = 2'b01;
      for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0);
      for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1);
      cyc(1'b0, 1'b1);
      cyc(1'b0, 1'b0);

      // trigger at 14: fill to full and beyond for overrun
      trig_sel = 2'b11;
      for (int i = 0; i < 18; i++) cyc(1'b1, 1'b0);
      cyc(1'b1, 1'b1);
      cyc(1'b1, 1'b1);
      for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1);
      cyc(1'b0, 1'b0);

      // sweep the select at a fixed level of 13
      for (int s = 0; s < 4; s++) begin
         trig_sel = 2'(s);
         cyc(1'b0, 1'b0);
      end

      // trigger at 8: cross downwards
      trig_sel = 2'b10;
      for (int i = 0; i < 7; i++) cyc(1'b0, 1'b1);
      cyc(1'b0, 1'b0);

      // interrupt disabled: data_ready keeps tracking
      rx_irq_en = 1'b0;
      for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1);
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0);
      cyc(1'b0, 1'b0);

      // queue mode off: trigger treated as one character
      rx_irq_en = 1'b1; fifo_en = 1'b0; trig_sel = 2'b11;
      for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1);
      cyc(1'b1, 1'b0);
      cyc(1'b0, 1'b1);
      cyc(1'b0, 1'b0);
      fifo_en = 1'b1;

      // mixed traffic
      for (int i = 0; i < 600; i++) begin
         lfsr = lfsr ^ (lfsr << 13);
         lfsr = lfsr ^ (lfsr >> 17);
         lfsr = lfsr ^ (lfsr << 5);
         if (lfsr[9:6] == 4'h0) trig_sel = lfsr[11:10];
         if (lfsr[15:12] == 4'h3) rx_irq_en = ~rx_irq_en;
         if (lfsr[19:16] == 4'h5) fifo_en = ~fifo_en;
         cyc(lfsr[0] | lfsr[1], lfsr[2] & (lfsr[3] | (i > 400)));
      end

      rx_irq_en = 1'b1; fifo_en = 1'b1;
      for (int i = 0; i < 20; i++) cyc(1'b0, 1'b1);
      cyc(1'b0, 1'b0);
      cyc(1'b0, 1'b0);

      summary();
      $finish;
   end

endmodule